// File: doc/BRIEF.md
# Pipelined Quadratic Evaluator

This block evaluates the second-order polynomial y = a·x² + b·x + c on a stream of signed samples, accepting one new x on every clock. The coefficients a, b and c are held steady by the surrounding logic while a stream is running. The arithmetic is cut into three balanced register-separated stages, so the block produces one result per clock at a fixed latency. None of the multipliers or adders is itself pipelined.

Stage one forms x·x and b·x. Stage two scales the square by a and adds c to the linear term. Stage three adds the two partial sums. A valid flag travels beside the data through the same three registers. Data registers are not reset. Only the valid chain is cleared by the synchronous, active-high reset.

Top module: `quad_pipe`

## Requirements
- R1: When valid_out is 1, y_out equals a·x² + b·x + c exactly, with signed arithmetic on the sample and coefficient values that were presented with that sample.
- R2: valid_out in any cycle equals valid_in three rising clock edges earlier, provided no reset occurred in that window.
- R3: A sample presented with valid_in = 1 before edge n appears on y_out with valid_out = 1 after edge n+2. valid_out stays 0 after edges n and n+1 if no other sample is in flight.
- R4: Samples on consecutive clocks give results on consecutive clocks, in the same order. Cycles with valid_in = 0 appear as cycles with valid_out = 0 in the same positions.
- R5: A reset clears every in-flight valid flag. After a reset edge, valid_out is 0 until a sample presented after reset reaches the output.
- R6: y_out is 3·XW bits signed. No combination of XW-bit signed inputs overflows it, including x = -128 with coefficients at -128 or 127.
- R7: A square formed in stage one is never negative, including for x = -128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| valid_in | input | 1 | Marks x_in as a sample this cycle |
| x_in | input | XW | Signed sample |
| coef_a | input | XW | Signed quadratic coefficient |
| coef_b | input | XW | Signed linear coefficient |
| coef_c | input | XW | Signed constant term |
| valid_out | output | 1 | Marks y_out as a result |
| y_out | output | 3*XW | Signed result |

## Verification
The bench targets the extreme operand values -128 and 127 in every sign mix. A design that sized its products or sums too narrowly, or treated an operand as unsigned, would return a wrapped or sign-flipped result. A back-to-back stream with regular bubbles would expose an off-by-one latency, a dropped or duplicated result, or a bubble that shifted position. A reset while samples are in flight checks that stale valid flags are cleared and cannot produce a spurious result afterwards.

// File: rtl/quad_pipe.sv
module quad_pipe #(
  parameter int XW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid_in,
  input  logic signed [XW-1:0]   x_in,
  input  logic signed [XW-1:0]   coef_a,
  input  logic signed [XW-1:0]   coef_b,
  input  logic signed [XW-1:0]   coef_c,
  output logic                   valid_out,
  output logic signed [3*XW-1:0] y_out
);

  localparam int W2 = 2 * XW;
  localparam int YW = 3 * XW;

  logic signed [W2-1:0] xw;
  logic signed [W2-1:0] sq1, bx1;
  logic signed [YW-1:0] ax2, bxc2;
  logic                 v1, v2, v3;

  assign xw = W2'(x_in);

  always_ff @(posedge clk) begin
    sq1  <= xw * xw;
    bx1  <= W2'(coef_b) * xw;
    ax2  <= YW'(coef_a) * YW'(sq1);
    bxc2 <= YW'(bx1) + YW'(coef_c);
    y_out <= ax2 + bxc2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= valid_in;
      v2 <= v1;
      v3 <= v2;
    end
  end

  assign valid_out = v3;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic signed [YW-1:0] model_y;
  assign model_y = YW'(coef_a) * YW'(x_in) * YW'(x_in) + YW'(coef_b) * YW'(x_in) + YW'(coef_c);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (valid_out == $past(valid_in, 3)));

  assert_value_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && valid_out) |-> (y_out == $past(model_y, 3)));

  assert_flush_R5: assert property (@(posedge clk)
    rst |=> !valid_out);

  assert_square_sign_R7: assert property (@(posedge clk) disable iff (rst)
    v1 |-> !sq1[W2-1]);

endmodule

// File: tb/quad_pipe_test.sv
module quad_pipe_test;
  localparam int PER = 10;
  localparam int XW = 8;
  localparam int NV = 10;

  localparam int VX[NV] = '{0, 1, 2, -3, 127, -128, -128, -128, 10, -5};
  localparam int VA[NV] = '{0, 1, 3, 2, 127, -128, 127, -128, -1, 0};
  localparam int VB[NV] = '{0, 1, -4, 7, 127, -128, -128, 127, 0, 3};
  localparam int VC[NV] = '{0, 1, 5, -1, 127, -128, 127, -128, 0, -7};
  localparam int VE[NV] = '{0, 3, 9, -4, 2064639, -2080896, 2097279, -2113536, -100, -22};

  logic clk = 0, rst = 1, valid_in = 0;
  logic signed [XW-1:0] x_in = 0, coef_a = 0, coef_b = 0, coef_c = 0;
  logic valid_out;
  logic signed [3*XW-1:0] y_out;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  quad_pipe #(.XW(XW)) uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .x_in(x_in),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .valid_out(valid_out), .y_out(y_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int poly(input int x, input int a, input int b, input int c);
    return a * x * x + b * x + c;
  endfunction

  int sx[64];
  bit sv[64];

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_out == 0, "R5 reset", valid_out, 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      x_in = XW'(VX[i]); coef_a = XW'(VA[i]); coef_b = XW'(VB[i]); coef_c = XW'(VC[i]);
      valid_in = 1;
      @(negedge clk);
      valid_in = 0;
      chk(valid_out == 0, "R3 early edge1", valid_out, 0);
      @(negedge clk);
      chk(valid_out == 0, "R3 early edge2", valid_out, 0);
      @(negedge clk);
      chk(valid_out == 1, "R3 arrival", valid_out, 1);
      chk(y_out == VE[i], (i >= 4 && i <= 7) ? "R6 extreme" : "R1 value", y_out, VE[i]);
    end

    coef_a = 3; coef_b = -2; coef_c = 7;
    for (int n = 0; n < 43; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        chk(valid_out == sv[n-3], "R4 valid order", valid_out, sv[n-3]);
        if (sv[n-3])
          chk(y_out == poly(sx[n-3], 3, -2, 7), "R4 stream value", y_out, poly(sx[n-3], 3, -2, 7));
      end
      if (n < 40) begin
        sx[n] = (n * 7) % 256 - 128;
        sv[n] = (n % 5) != 3;
        x_in = XW'(sx[n]);
        valid_in = sv[n];
      end else begin
        valid_in = 0;
      end
    end

    @(negedge clk);
    x_in = 5; valid_in = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 1; valid_in = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rst = 0;
      chk(valid_out == 0, "R5 flush", valid_out, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PER * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule